// File: doc/BRIEF.md
# Transmit Descriptor Frame Engine

This block sits between a host and a byte-wide frame sink. The host writes frame data, one 32-bit word at a time, into a 16384-byte circular transmit buffer. Each write lands at a write pointer that steps by four and wraps at the end of the buffer. An optional byte-swap input reverses each word before it is stored. The host also fills a small ring of transmit descriptors. Each descriptor holds a ready flag, a byte length and a 16-bit buffer pointer. A separate pulse raises the count of frames waiting to go out.

A start pulse makes the engine walk the ring from its current index, at most once per frame counted when the walk begins. Each ready descriptor streams its bytes, one per cycle, with start and end markers. The buffer offset is the descriptor pointer minus 0x1000, taken modulo the buffer size, and a frame that runs past the end of the buffer continues from offset zero. After each descriptor the engine clears its ready flag, moves to the next ring slot and lowers the pending count. At the end of the walk it pulses one interrupt for normal completion and a separate one for a short or empty walk. A transmit reset puts the pointers and counters back to their initial state.

Top module: `tx_desc_engine`

## Requirements
- R1: Each cycle with `wr_en` high stores `wr_data` at the word addressed by `wr_ptr`, and `wr_ptr` then advances by 4 modulo 16384 (0 follows 16380).
- R2: Byte k of the stored word (bits 8k+7:8k, k=0..3) occupies byte address `wr_ptr`+k. With `swap_en` high the incoming word is byte-reversed before storing, so byte 0 holds `wr_data[31:24]`.
- R3: A `frame_inc` pulse raises `frame_cnt` by one.
- R4: On `start`, the engine captures `frame_cnt` as its target and handles descriptors in ring order until it has handled that many. Each sent frame appears on `out_data` as consecutive `out_valid` cycles, with `out_sof` on the first byte and `out_eof` on the last byte.
- R5: The walk ends at once, without retiring anything, when the current descriptor's ready flag is clear.
- R6: A ready descriptor whose length is above 1514, or is zero, produces no output but is still retired. A length of exactly 1514 is sent.
- R7: A frame's first byte is read at offset (pointer − 0x1000) mod 16384. Successive bytes read at offset+1, offset+2 and so on, modulo 16384, so the frame wraps to offset 0.
- R8: Retiring a descriptor clears its bit in `desc_ready`, advances `desc_idx` modulo 8 (7 wraps to 0) and lowers `frame_cnt` by one.
- R9: `irq_dnv` pulses for one cycle at the end of a walk when the number handled differs from the target, or when the target was zero.
- R10: `irq_end` pulses for one cycle at the end of a walk in which at least one descriptor was retired.
- R11: A `tx_reset` pulse sets `wr_ptr`, `desc_idx` and `frame_cnt` to zero, sets `size_reg` to 16384 and abandons any walk in progress or held start. The same state follows `rst_n`.
- R12: A `start` that arrives while a walk is running is held. A second walk begins after the first ends, with its target taken from `frame_cnt` at that time. `busy` stays high until no walk is running or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_en | input | 1 | Byte-reverse data-port words before storing |
| wr_en | input | 1 | Data-port write strobe |
| wr_data | input | 32 | Data-port word |
| frame_inc | input | 1 | Add one pending frame |
| desc_we | input | 1 | Descriptor write strobe |
| desc_sel | input | 3 | Descriptor slot to write |
| desc_len | input | 16 | Frame length in bytes |
| desc_ptr | input | 16 | Frame pointer (buffer offset plus 0x1000) |
| desc_rdy | input | 1 | Ready flag written with the descriptor |
| tx_reset | input | 1 | Transmit-side reset pulse |
| start | input | 1 | Start a descriptor walk |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte valid |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| irq_end | output | 1 | Walk ended with descriptors retired |
| irq_dnv | output | 1 | Walk ended short or with zero target |
| busy | output | 1 | Walk running or held |
| wr_ptr | output | 14 | Data-port write pointer |
| frame_cnt | output | 8 | Pending frame count |
| desc_idx | output | 3 | Current descriptor slot |
| desc_ready | output | 8 | Ready flags of all slots |
| size_reg | output | 15 | Buffer size register |

## Verification
The counter assertions assume that `frame_inc` and a retire never fall in the same cycle, unless the combined update is what they check. The checks on descriptor and buffer contents assume that the host does not rewrite a descriptor or the buffer while a walk is running. The stimulus meets both assumptions by driving data writes, descriptor writes and increment pulses only while `busy` is low. Inside a walk, the only other pulse it sends is a second `start`, issued a few cycles in to exercise the held-start path. Random lengths, pointers and ready flags give wrapping offsets and oversize lengths, while directed cases cover the 1514/1515 boundary, the zero target and the ring index wrap.

// File: rtl/tx_desc_engine.sv
module tx_desc_engine #(
  parameter int BUF_BYTES = 16384,
  parameter int NDESC     = 8,
  parameter int MAX_LEN   = 1514,
  parameter int PTR_BASE  = 'h1000,
  parameter int CNT_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          swap_en,
  input  logic                          wr_en,
  input  logic [31:0]                   wr_data,
  input  logic                          frame_inc,
  input  logic                          desc_we,
  input  logic [$clog2(NDESC)-1:0]      desc_sel,
  input  logic [15:0]                   desc_len,
  input  logic [15:0]                   desc_ptr,
  input  logic                          desc_rdy,
  input  logic                          tx_reset,
  input  logic                          start,
  output logic [7:0]                    out_data,
  output logic                          out_valid,
  output logic                          out_sof,
  output logic                          out_eof,
  output logic                          irq_end,
  output logic                          irq_dnv,
  output logic                          busy,
  output logic [$clog2(BUF_BYTES)-1:0]  wr_ptr,
  output logic [CNT_W-1:0]              frame_cnt,
  output logic [$clog2(NDESC)-1:0]      desc_idx,
  output logic [NDESC-1:0]              desc_ready,
  output logic [$clog2(BUF_BYTES):0]    size_reg
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int IW = $clog2(NDESC);
  localparam int WORDS = BUF_BYTES / 4;
  localparam logic [15:0] MAXL = 16'(MAX_LEN);
  localparam logic [15:0] BASE = 16'(PTR_BASE);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SEND, S_RETIRE, S_DONE} st_t;
  st_t st;

  logic [31:0]      mem [WORDS];
  logic [15:0]      d_len [NDESC];
  logic [15:0]      d_ptr [NDESC];
  logic [AW-1:0]    rd_addr;
  logic [15:0]      remain;
  logic             first, pend;
  logic [CNT_W-1:0] target, done_cnt;

  wire [31:0]   wr_word = swap_en ? {wr_data[7:0], wr_data[15:8], wr_data[23:16], wr_data[31:24]} : wr_data;
  wire [15:0]   cur_len = d_len[desc_idx];
  wire [AW-1:0] cur_off = AW'(d_ptr[desc_idx] - BASE);
  wire [31:0]   rd_word = mem[rd_addr[AW-1:2]];
  wire          retiring = (st == S_RETIRE);

  assign out_valid = (st == S_SEND);
  assign out_data  = rd_word[8*rd_addr[1:0] +: 8];
  assign out_sof   = out_valid && first;
  assign out_eof   = out_valid && (remain == 16'd1);
  assign irq_end   = (st == S_DONE) && (done_cnt != '0);
  assign irq_dnv   = (st == S_DONE) && ((done_cnt != target) || (target == '0));
  assign busy      = (st != S_IDLE) || pend;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:2]] <= wr_word;
    if (desc_we) begin
      d_len[desc_sel] <= desc_len;
      d_ptr[desc_sel] <= desc_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_ready <= '0;
    end else begin
      if (desc_we) desc_ready[desc_sel] <= desc_rdy;
      if (retiring) desc_ready[desc_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; wr_ptr <= '0; frame_cnt <= '0; desc_idx <= '0;
      size_reg <= (AW+1)'(BUF_BYTES); rd_addr <= '0; remain <= '0; first <= 1'b0;
      target <= '0; done_cnt <= '0;
    end else if (tx_reset) begin
      st <= S_IDLE; pend <= 1'b0; wr_ptr <= '0; frame_cnt <= '0; desc_idx <= '0;
      size_reg <= (AW+1)'(BUF_BYTES); rd_addr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(4);
      frame_cnt <= frame_cnt + CNT_W'(frame_inc) - CNT_W'(retiring);
      if (start && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (start || pend) begin
          pend <= 1'b0; target <= frame_cnt; done_cnt <= '0; st <= S_CHECK;
        end
        S_CHECK:
          if (done_cnt == target || !desc_ready[desc_idx]) st <= S_DONE;
          else if (cur_len == 16'd0 || cur_len > MAXL) st <= S_RETIRE;
          else begin
            rd_addr <= cur_off; remain <= cur_len; first <= 1'b1; st <= S_SEND;
          end
        S_SEND: begin
          rd_addr <= rd_addr + AW'(1);
          remain  <= remain - 16'd1;
          first   <= 1'b0;
          if (remain == 16'd1) st <= S_RETIRE;
        end
        S_RETIRE: begin
          desc_idx <= (desc_idx == IW'(NDESC-1)) ? '0 : desc_idx + IW'(1);
          done_cnt <= done_cnt + CNT_W'(1);
          st <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !tx_reset |=> wr_ptr == $past(wr_ptr) + AW'(4));
  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    frame_inc && !retiring && !tx_reset |=> frame_cnt == $past(frame_cnt) + CNT_W'(1));
  a_r8_retire_dec: assert property (@(posedge clk) disable iff (!rst_n)
    retiring && !frame_inc && !tx_reset |=> frame_cnt == $past(frame_cnt) - CNT_W'(1));
  a_r6_len_ok: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (remain != 16'd0) && (remain <= MAXL));
  a_r4_sof_once: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);
  a_r11_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> wr_ptr == '0 && frame_cnt == '0 && desc_idx == '0 && !busy);
  a_r9_irq_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_end || irq_dnv) |-> !out_valid);
endmodule

// File: tb/tx_desc_engine_bench.sv
module tx_desc_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic swap_en = 0, wr_en = 0, frame_inc = 0, desc_we = 0, desc_rdy = 0, tx_reset = 0, start = 0;
  logic [31:0] wr_data = '0;
  logic [2:0] desc_sel = '0;
  logic [15:0] desc_len = '0, desc_ptr = '0;
  logic [7:0] out_data;
  logic out_valid, out_sof, out_eof, irq_end, irq_dnv, busy;
  logic [13:0] wr_ptr;
  logic [7:0] frame_cnt;
  logic [2:0] desc_idx;
  logic [7:0] desc_ready;
  logic [14:0] size_reg;

  always #2 clk = ~clk;

  tx_desc_engine u_tx_desc_engine (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .wr_en(wr_en), .wr_data(wr_data),
    .frame_inc(frame_inc), .desc_we(desc_we), .desc_sel(desc_sel), .desc_len(desc_len),
    .desc_ptr(desc_ptr), .desc_rdy(desc_rdy), .tx_reset(tx_reset), .start(start),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .irq_end(irq_end), .irq_dnv(irq_dnv), .busy(busy), .wr_ptr(wr_ptr),
    .frame_cnt(frame_cnt), .desc_idx(desc_idx), .desc_ready(desc_ready), .size_reg(size_reg));

  int nchk = 0, nfail = 0;
  logic [7:0]  bmem [16384];
  logic [15:0] m_len [8];
  logic [15:0] m_ptr [8];
  logic [7:0]  m_rdy = '0;
  int m_idx = 0, m_cnt = 0, m_wp = 0;
  logic [9:0] got_q[$];
  logic [9:0] exp_q[$];
  int n_end = 0, n_dnv = 0;

  always @(negedge clk) begin
    if (out_valid) got_q.push_back({out_sof, out_eof, out_data});
    if (irq_end) n_end++;
    if (irq_dnv) n_dnv++;
  end

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic write_word(logic [31:0] w);
    logic [31:0] s;
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
    s = swap_en ? bswap(w) : w;
    for (int k = 0; k < 4; k++) bmem[(m_wp + k) & 16383] = s[8*k +: 8];
    m_wp = (m_wp + 4) & 16383;
  endtask

  task automatic write_desc(int i, int len, int ptr, bit rdy);
    @(negedge clk); desc_we = 1; desc_sel = 3'(i); desc_len = 16'(len); desc_ptr = 16'(ptr); desc_rdy = rdy;
    @(negedge clk); desc_we = 0;
    m_len[i] = 16'(len); m_ptr[i] = 16'(ptr); m_rdy[i] = rdy;
  endtask

  task automatic inc_frame();
    @(negedge clk); frame_inc = 1;
    @(negedge clk); frame_inc = 0;
    m_cnt++;
  endtask

  task automatic model_walk(inout int e_end, inout int e_dnv);
    int tgt = m_cnt, done = 0;
    while (done < tgt && m_rdy[m_idx]) begin
      int len = m_len[m_idx];
      int off = (m_ptr[m_idx] - 'h1000) & 16383;
      if (len != 0 && len <= 1514)
        for (int i = 0; i < len; i++)
          exp_q.push_back({(i == 0), (i == len - 1), bmem[(off + i) & 16383]});
      m_rdy[m_idx] = 0; m_idx = (m_idx + 1) % 8; m_cnt--; done++;
    end
    if (done != 0) e_end++;
    if (done != tgt || tgt == 0) e_dnv++;
  endtask

  task automatic run_walk(string tag, int nstart);
    int e_end = 0, e_dnv = 0;
    chk("R3", "frame_cnt before walk", frame_cnt, m_cnt);
    got_q.delete(); exp_q.delete(); n_end = 0; n_dnv = 0;
    for (int s = 0; s < nstart; s++) model_walk(e_end, e_dnv);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (nstart > 1) begin
      @(negedge clk); @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(tag, "byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin
        chk(tag, $sformatf("byte %0d {sof,eof,data}", i), got_q[i], exp_q[i]);
        break;
      end
    chk("R10", "irq_end pulses", n_end, e_end);
    chk("R9", "irq_dnv pulses", n_dnv, e_dnv);
    chk("R8", "desc_idx", desc_idx, m_idx);
    chk("R8", "desc_ready", desc_ready, m_rdy);
    chk("R8", "frame_cnt after walk", frame_cnt, m_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "reset wr_ptr", wr_ptr, 0);
    chk("R11", "reset frame_cnt", frame_cnt, 0);
    chk("R11", "reset size_reg", size_reg, 16384);
    chk("R11", "reset busy", busy, 0);
    chk("R11", "reset out_valid", out_valid, 0);

    for (int i = 0; i < 2048; i++) write_word($urandom);
    chk("R1", "wr_ptr half fill", wr_ptr, 8192);
    swap_en = 1;
    for (int i = 0; i < 2048; i++) write_word($urandom);
    swap_en = 0;
    chk("R1", "wr_ptr wrapped", wr_ptr, 0);

    run_walk("R9", 1);

    write_desc(0, 8, 'h1000 + 8192, 1);
    write_desc(1, 13, 'h1000 + 100, 1);
    inc_frame(); inc_frame();
    run_walk("R2", 1);

    write_desc(2, 20, 'h1000 + 16380, 1);
    write_desc(3, 9, 'h0FFE, 1);
    inc_frame(); inc_frame();
    run_walk("R7", 1);

    write_desc(4, 1600, 'h1000, 1);
    write_desc(5, 1514, 'h1000 + 16000, 1);
    write_desc(6, 1515, 'h1000, 1);
    write_desc(7, 0, 'h1000, 1);
    inc_frame(); inc_frame(); inc_frame(); inc_frame();
    run_walk("R6", 1);

    write_desc(0, 5, 'h1200, 1);
    write_desc(1, 6, 'h1300, 0);
    inc_frame(); inc_frame(); inc_frame();
    run_walk("R5", 1);
    chk("R5", "count left after stop", frame_cnt, 2);

    write_desc(1, 6, 'h1300, 1);
    write_desc(2, 7, 'h1400, 1);
    run_walk("R4", 1);

    for (int i = 3; i < 8; i++) write_desc(i, 4 + i, 'h2000 + 40 * i, 1);
    write_desc(0, 11, 'h3000, 1);
    for (int i = 0; i < 6; i++) inc_frame();
    run_walk("R8", 1);
    chk("R8", "index wrapped past 7", desc_idx, 1);

    write_desc(1, 30, 'h1500, 1);
    write_desc(2, 25, 'h1600, 1);
    inc_frame(); inc_frame();
    run_walk("R12", 2);

    inc_frame(); inc_frame();
    write_word(32'hA5A5_0001);
    write_word(32'hA5A5_0002);
    @(negedge clk); tx_reset = 1;
    @(negedge clk); tx_reset = 0;
    m_wp = 0; m_idx = 0; m_cnt = 0;
    chk("R11", "tx_reset wr_ptr", wr_ptr, 0);
    chk("R11", "tx_reset frame_cnt", frame_cnt, 0);
    chk("R11", "tx_reset desc_idx", desc_idx, 0);
    chk("R11", "tx_reset size_reg", size_reg, 16384);
    run_walk("R11", 1);

    for (int r = 0; r < 25; r++) begin
      int n = 1 + ($urandom % 4);
      for (int k = 0; k < n; k++) begin
        int len = ($urandom % 8 == 0) ? 1510 + ($urandom % 10) : 1 + ($urandom % 64);
        write_desc((m_idx + k) % 8, len, $urandom % 65536, ($urandom % 10) != 0);
      end
      if ($urandom % 2 == 0) begin
        swap_en = $urandom % 2;
        write_word($urandom);
        swap_en = 0;
      end
      for (int k = 0; k < n + ($urandom % 2); k++) inc_frame();
      run_walk("R4", 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule